// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers a word of level-sensitive, active-high interrupt request lines and fans them out to four output lines: an ordinary interrupt line and a machine-check line for each of two processor cores. Every output has its own enable mask of the same width as the source word. An output is high while at least one source is active and also enabled in that output's mask.

Nothing is latched. The status word follows the synchronised input levels. No acknowledge register exists, so an output drops only when the device lowers its request or when software clears the mask bit. The outputs are not arbitrated. One source that is enabled in several masks drives every one of those lines at the same time.

Software reaches the block through a plain register port: a one-cycle strobe with a write flag, a byte address and a data word. Read data is registered. It is valid in the cycle after the strobe and holds until the next read. The port has no back-pressure, because every access completes in one cycle.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset all four mask registers read 0x00000000, every output line is low, and the read data is zero.
- R2: A read of offset 0x00 returns the status word, where bit n is the level of source n. A level change on a source appears in the status word two clock edges after it is applied.
- R3: The mask registers are at these offsets: core 0 interrupt mask at 0x10, core 1 interrupt mask at 0x14, core 0 machine-check mask at 0x18, and core 1 machine-check mask at 0x1C. A write to one of these offsets stores the data word, and a read of the same offset returns the stored word.
- R4: irq_out[c] is the registered OR of (status AND interrupt mask c). A source change reaches this output three clock edges after it is applied, and a mask write reaches it one edge after the write.
- R5: mchk_out[c] follows the same rule as R4, using machine-check mask c.
- R6: A single active source that is enabled in several masks asserts every corresponding output line at the same time.
- R7: An asserted output deasserts when its enabled sources go low, with no acknowledge access.
- R8: Clearing a mask bit removes that source from the output. An all-zero mask keeps its output low even when every source is active.
- R9: Writes to offset 0x00 or to any unmapped offset change no mask. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level-sensitive interrupt requests, active high |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| irq_out | output | 2 | Interrupt line for each core |
| mchk_out | output | 2 | Machine-check line for each core |

## Verification
The hardest case to produce is one source that drives several lines at once, followed by the release of each line by a different means: by the source going low, or by one mask bit being cleared. No acknowledge path exists to force that release. The vector table loads all four masks with chosen overlaps before applying each source pattern, so that fan-out and blocking are both observed from the ports. The directed tests then release lines one way at a time. One test counts edges after a source change, to pin the three-stage latency.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int unsigned STATUS_OFS = 32'h00;
  localparam int unsigned MASK_BASE  = 32'h10;
  localparam int unsigned MASK_STEP  = 4;
endpackage

// File: rtl/lia_sync.sv
module lia_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lia_regfile.sv
module lia_regfile
  import lia_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_en,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WIDTH-1:0]            bus_wdata,
  input  logic [WIDTH-1:0]            status,
  output logic [WIDTH-1:0]            rdata,
  output logic [N_OUT-1:0][WIDTH-1:0] mask
);
  logic [N_OUT-1:0] sel;
  logic             sel_status;
  logic [WIDTH-1:0] rd_mux;

  assign sel_status = (bus_addr == ADDR_W'(STATUS_OFS));

  for (genvar k = 0; k < N_OUT; k++) begin : g_mask
    assign sel[k] = (bus_addr == ADDR_W'(MASK_BASE + MASK_STEP * k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask[k] <= '0;
      else if (bus_en && bus_we && sel[k]) mask[k] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_status) rd_mux = status;
    for (int k = 0; k < N_OUT; k++)
      if (sel[k]) rd_mux = mask[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata <= '0;
    else if (bus_en && !bus_we) rdata <= rd_mux;
  end
endmodule

// File: rtl/lia_gate.sv
module lia_gate #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] enable,
  output logic             line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= |(status & enable);
  end
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned N_CORE      = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic [N_CORE-1:0] irq_out,
  output logic [N_CORE-1:0] mchk_out
);
  localparam int unsigned N_OUT = 2 * N_CORE;

  logic [N_SRC-1:0]            status_w;
  logic [N_OUT-1:0][N_SRC-1:0] mask_w;
  logic [N_OUT-1:0]            line_w;

  lia_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_src), .q(status_w)
  );

  lia_regfile #(.WIDTH(N_SRC), .N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_w),
    .rdata(bus_rdata), .mask(mask_w)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    lia_gate #(.WIDTH(N_SRC)) u_gate (
      .clk(clk), .rst_n(rst_n), .status(status_w),
      .enable(mask_w[k]), .line_q(line_w[k])
    );
  end

  assign irq_out  = line_w[N_CORE-1:0];
  assign mchk_out = line_w[N_OUT-1:N_CORE];
endmodule

// File: rtl/lvl_irq_agg_chk.sv
module lvl_irq_agg_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CORE = 2,
  parameter int unsigned ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_en,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [N_SRC-1:0]              bus_wdata,
  input logic [N_SRC-1:0]              bus_rdata,
  input logic [N_CORE-1:0]             irq_out,
  input logic [N_CORE-1:0]             mchk_out,
  input logic [N_SRC-1:0]              status_w,
  input logic [2*N_CORE-1:0][N_SRC-1:0] mask_w
);
  localparam int unsigned N_OUT = 2 * N_CORE;
  logic [N_OUT-1:0] lines;
  logic             mapped;
  logic             mask_hit;
  logic [N_SRC-1:0] hit_word;
  assign lines = {mchk_out, irq_out};

  always_comb begin
    mask_hit = 1'b0;
    hit_word = '0;
    for (int k = 0; k < N_OUT; k++)
      if (bus_addr == ADDR_W'(16 + 4 * k)) mask_hit = 1'b1;
    mapped = mask_hit || (bus_addr == '0);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lines == '0 && bus_rdata == '0));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !mask_hit) |=> $stable(mask_w));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !mapped) |=> (bus_rdata == '0));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    // R3
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'(16 + 4 * k)) |=> (mask_w[k] == $past(bus_wdata)));
    // R4
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lines[k] == $past(|(status_w & mask_w[k])));
    // R8
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_w[k] == '0) |=> !lines[k]);
  end
endmodule

bind lvl_irq_agg lvl_irq_agg_chk #(.N_SRC(N_SRC), .N_CORE(N_CORE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .mchk_out(mchk_out),
  .status_w(status_w), .mask_w(mask_w)
);

// File: tb/test_lvl_irq_agg.sv
module test_lvl_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;
  logic [1:0]  mchk_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  lvl_irq_agg i_lvl_irq_agg (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .mchk_out(mchk_out)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] m_i0;
    logic [31:0] m_i1;
    logic [31:0] m_c0;
    logic [31:0] m_c1;
    logic [3:0]  exp;   // {mchk1, mchk0, irq1, irq0}
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h00000001, 32'h00000001, 32'h0,        32'h0,        32'h0,        4'b0001},
    '{32'h00010000, 32'h0000FFFF, 32'h00010000, 32'h0,        32'h0,        4'b0010},
    '{32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 4'b1111},
    '{32'h0000F000, 32'h00000F00, 32'h000000FF, 32'h0,        32'h0,        4'b0000},
    '{32'h00000024, 32'h0,        32'h0,        32'h00000004, 32'h00000020, 4'b1100},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0,        4'b0000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] lines();
    return {28'h0, mchk_out, irq_out};
  endfunction

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lines", lines(), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    for (int a = 16; a < 32; a += 4) begin
      rd(8'(a), r);
      check("R1 mask reset", r, 32'h0);
    end

    // table walk: R4 R5 R6 R8
    foreach (VECS[i]) begin
      irq_src = VECS[i].src;
      wr(8'h10, VECS[i].m_i0);
      wr(8'h14, VECS[i].m_i1);
      wr(8'h18, VECS[i].m_c0);
      wr(8'h1C, VECS[i].m_c1);
      settle();
      check("R4/R5/R6/R8 table", lines(), {28'h0, VECS[i].exp});
      rd(8'h00, r);
      check("R2 status", r, VECS[i].src);
      rd(8'h14, r);
      check("R3 readback", r, VECS[i].m_i1);
      rd(8'h18, r);
      check("R3 readback mc0", r, VECS[i].m_c0);
    end

    // R2 / R4 latency: source change seen on output at third edge
    wr(8'h10, 32'h00000100);
    wr(8'h1C, 32'h0);
    irq_src = 32'h0;
    settle();
    @(negedge clk);
    irq_src = 32'h00000100;
    @(negedge clk);
    @(negedge clk);
    check("R4 latency before", lines(), 32'h0);
    @(negedge clk);
    check("R4 latency after", lines(), 32'h1);

    // R6 fan-out then R7 release by source drop
    wr(8'h14, 32'h00000100);
    wr(8'h18, 32'h00000100);
    settle();
    check("R6 fan-out", lines(), 32'h7);
    irq_src = 32'h0;
    settle();
    check("R7 release", lines(), 32'h0);

    // R8 clear one mask bit, others keep driving
    irq_src = 32'h00000100;
    settle();
    wr(8'h14, 32'h00000000);
    @(negedge clk);
    check("R8 mask clear", lines(), 32'h5);
    // R5 machine-check alone
    wr(8'h10, 32'h0);
    settle();
    check("R5 mchk only", lines(), 32'h4);

    // R9 ignored writes and unmapped reads
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h11, 32'hFFFFFFFF);
    settle();
    check("R9 lines kept", lines(), 32'h4);
    rd(8'h10, r);
    check("R9 mask kept", r, 32'h0);
    rd(8'h00, r);
    check("R9 status kept", r, 32'h00000100);
    rd(8'h08, r);
    check("R9 unmapped read", r, 32'h0);
    rd(8'h40, r);
    check("R9 unmapped read hi", r, 32'h0);

    // R1 reset clears masks and lines mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset lines", lines(), 32'h0);
    rst_n = 1'b1;
    rd(8'h18, r);
    check("R1 mask after reset", r, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule